// File: doc/BRIEF.md
# Cassette Tape Operation Sequencer

This block carries out a single cassette tape command on one of two drives. The host presents a three-bit function code with a drive number and a start strobe. The block decides which way the tape moves and refuses motion past either end of the tape. It keeps, for each drive, the last direction of travel and whether the last command ended on a file gap. It then drives a small set of step commands towards the tape medium. Those commands advance or back up one item, consume a record byte, store a byte, lay down a gap, rewind, or close a written record.

Reads and writes proceed one character at a time. Each character raises a transfer request that the host clears with an acknowledge. When the host holds its end-of-record flag, the block takes one further character, waits a start delay, and closes the record. Cassette file gaps behave differently from tape marks. A gap that was just crossed is not seen again when the direction reverses. A forward read or space command that starts at the beginning of tape first steps over the leading gap.

Top module: `cassette_seq`

## Requirements
- R1: Function codes: 0 lays a file gap, 1 writes, 2 reads, 3 spaces back to a gap, 4 spaces back one item, 5 spaces forward to a gap, 6 spaces forward one item, 7 rewinds. Codes 0, 1, 2, 5 and 6 move forward, 3 and 4 move back, and 7 has neither direction. Step codes on `t_op` are: 0 advance one item (or leave the current record), 1 back up one item (or return to the start of the current record), 2 consume a byte, 3 store `t_wdata`, 4 lay a gap, 5 rewind, 6 close the written record.
- R2: After the start delay, a forward command at end of tape or a reverse command at beginning of tape ends with error and end-of-tape set, ready raised, and no step issued.
- R3: A write or gap command on a drive reporting `t_wlock` ends in the cycle after the strobe with error and write-lock set and ready high, and busy is never raised.
- R4: A read or space command moving forward from beginning of tape steps over a leading gap without reporting end-of-file.
- R5: A command that ends with end-of-file marks its drive as having hit a gap. If the next read or space command on that drive moves the other way, one item is stepped over in the new direction before the command runs, with no flag raised.
- R6: A read delivers one record byte on `rx_byte` every `CHAR_DLY` cycles and raises `xfer_req`. The request is cleared by `ack` or `crc_flag`.
- R7: While `crc_flag` is held, the next byte is consumed without a transfer request. After `START_DLY` cycles the rest of the record is skipped and the command ends without error.
- R8: A read that finds no byte left sets error and CRC, clears `rx_byte` and stops without leaving the record. A read that starts on a gap steps over it and ends with error and end-of-file.
- R9: A new character that arrives while `xfer_req` is still pending and not being acknowledged sets error and timing.
- R10: A write raises `xfer_req` at its start. Each later character stores the last acknowledged `tx_byte`. Once `crc_flag` is seen, no byte is stored and the record is closed after `START_DLY` cycles.
- R11: Space-to-gap commands step until a gap is crossed and set end-of-file without error. Space forward one item always sets CRC without error. Spacing one item onto a gap sets error and end-of-file.
- R12: Rewind returns the tape to beginning of tape and sets end-of-tape without error. Code 0 lays one gap without error.
- R13: A start strobe while busy is ignored.
- R14: After reset the block is idle and ready, with no flags and no transfer request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| go | input | 1 | Start strobe |
| go_unit | input | UW | Drive number |
| go_fn | input | 3 | Function code |
| crc_flag | input | 1 | Host end-of-record flag |
| ack | input | 1 | Host has taken or supplied a character |
| tx_byte | input | 8 | Host write character |
| busy | output | 1 | Command in progress |
| ready | output | 1 | Idle, command complete |
| xfer_req | output | 1 | Character transfer request |
| rx_byte | output | 8 | Last character read |
| err | output | 1 | Error summary |
| f_crc | output | 1 | CRC or data error |
| f_beot | output | 1 | At beginning or end of tape |
| f_wlk | output | 1 | Write-lock violation |
| f_eof | output | 1 | File gap found |
| f_tim | output | 1 | Transfer request overrun |
| t_unit | output | UW | Drive addressed on the medium side |
| t_step | output | 1 | Step strobe to the medium |
| t_op | output | 3 | Step code |
| t_wdata | output | 8 | Byte to store |
| t_bot | input | 1 | Medium at beginning of tape |
| t_eot | input | 1 | Medium at end of tape |
| t_wlock | input | 1 | Drive write-locked |
| t_fgap | input | 1 | Next item forward is a gap |
| t_rgap | input | 1 | Item behind the head is a gap |
| t_avail | input | 1 | Record byte available |
| t_data | input | 8 | Record byte under the head |

## Verification
The assertions assume that the medium's status inputs describe the selected drive and change only after a step. They also assume that the host holds `crc_flag` until the command completes. The bench's tape model updates position only on `t_step` edges. Its host tasks keep `crc_flag` asserted until ready returns, so both assumptions hold throughout. Random read lengths are drawn against records on a gap-free drive, so the expected bytes and flags follow from the record length alone.

// File: rtl/cassette_seq.sv
module cassette_seq #(
  parameter int NDRV = 2,
  parameter int START_DLY = 16,
  parameter int CHAR_DLY = 6,
  localparam int UW = (NDRV > 1) ? $clog2(NDRV) : 1,
  localparam int DMAX = (START_DLY > CHAR_DLY) ? START_DLY : CHAR_DLY,
  localparam int CW = $clog2(DMAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [UW-1:0] go_unit,
  input  logic [2:0]    go_fn,
  input  logic          crc_flag,
  input  logic          ack,
  input  logic [7:0]    tx_byte,
  output logic          busy,
  output logic          ready,
  output logic          xfer_req,
  output logic [7:0]    rx_byte,
  output logic          err,
  output logic          f_crc,
  output logic          f_beot,
  output logic          f_wlk,
  output logic          f_eof,
  output logic          f_tim,
  output logic [UW-1:0] t_unit,
  output logic          t_step,
  output logic [2:0]    t_op,
  output logic [7:0]    t_wdata,
  input  logic          t_bot,
  input  logic          t_eot,
  input  logic          t_wlock,
  input  logic          t_fgap,
  input  logic          t_rgap,
  input  logic          t_avail,
  input  logic [7:0]    t_data
);
  localparam logic [2:0] OP_FWD = 3'd0, OP_REV = 3'd1, OP_TAKE = 3'd2, OP_PUT = 3'd3,
                         OP_GAP = 3'd4, OP_REW = 3'd5, OP_CLOSE = 3'd6;
  typedef enum logic [3:0] {S_IDLE, S_BOTGAP, S_REVGAP, S_WAIT, S_EXEC,
                            S_RCH, S_WCH, S_CRC, S_SPACE} st_t;

  st_t st;
  logic [UW-1:0] unit_q;
  logic [2:0] fn_q;
  logic [CW-1:0] cnt;
  logic [NDRV-1:0] rev_d, gap_d;
  logic og, orv;
  logic [7:0] wbuf;

  wire mv_fwd  = (fn_q <= 3'd2) || (fn_q == 3'd5) || (fn_q == 3'd6);
  wire mv_rev  = (fn_q == 3'd3) || (fn_q == 3'd4);
  wire bad_mv  = (mv_fwd && t_eot) || (mv_rev && t_bot);
  wire xf_held = xfer_req && !ack && !crc_flag;
  wire sp_gap  = mv_rev ? t_rgap : t_fgap;
  wire sp_end  = mv_rev ? t_bot : t_eot;
  wire go_wr   = go_fn <= 3'd1;
  wire go_rs   = (go_fn >= 3'd2) && (go_fn <= 3'd6);
  wire go_rev  = (go_fn == 3'd3) || (go_fn == 3'd4);

  assign busy    = st != S_IDLE;
  assign t_unit  = busy ? unit_q : go_unit;
  assign t_wdata = wbuf;

  always_comb begin
    t_step = 1'b0;
    t_op   = OP_FWD;
    case (st)
      S_BOTGAP: t_step = mv_fwd && t_bot && t_fgap;
      S_REVGAP: begin t_step = og && (orv != mv_rev); t_op = mv_rev ? OP_REV : OP_FWD; end
      S_EXEC: if (!bad_mv)
        case (fn_q)
          3'd0: begin t_step = 1'b1; t_op = OP_GAP; end
          3'd2: t_step = t_fgap;
          3'd4: begin t_step = 1'b1; t_op = OP_REV; end
          3'd6: t_step = 1'b1;
          3'd7: begin t_step = 1'b1; t_op = OP_REW; end
          default: ;
        endcase
      S_RCH: begin t_step = (cnt == '0) && t_avail; t_op = OP_TAKE; end
      S_WCH: begin t_step = (cnt == '0) && !crc_flag; t_op = OP_PUT; end
      S_CRC: begin t_step = cnt == '0; t_op = (fn_q == 3'd1) ? OP_CLOSE : OP_FWD; end
      S_SPACE: begin t_step = sp_gap || !sp_end; t_op = mv_rev ? OP_REV : OP_FWD; end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; ready <= 1'b1; xfer_req <= 1'b0; rx_byte <= '0;
      {err, f_crc, f_beot, f_wlk, f_eof, f_tim} <= '0;
      unit_q <= '0; fn_q <= '0; cnt <= '0; rev_d <= '0; gap_d <= '0;
      og <= 1'b0; orv <= 1'b0; wbuf <= '0;
    end else begin
      if (ack || crc_flag) xfer_req <= 1'b0;
      if (ack && fn_q == 3'd1) wbuf <= tx_byte;
      case (st)
        S_IDLE: if (go) begin
          unit_q <= go_unit; fn_q <= go_fn; wbuf <= '0; xfer_req <= 1'b0;
          {err, f_crc, f_beot, f_wlk, f_eof, f_tim} <= '0;
          if (go_wr && t_wlock) begin
            err <= 1'b1; f_wlk <= 1'b1; ready <= 1'b1;
          end else begin
            ready <= 1'b0; og <= gap_d[go_unit]; orv <= rev_d[go_unit];
            rev_d[go_unit] <= go_rs && go_rev; gap_d[go_unit] <= 1'b0;
            if (go_rs) st <= S_BOTGAP;
            else begin st <= S_WAIT; cnt <= CW'(START_DLY - 1); end
          end
        end
        S_BOTGAP: begin if (t_step) og <= 1'b0; st <= S_REVGAP; end
        S_REVGAP: begin st <= S_WAIT; cnt <= CW'(START_DLY - 1); end
        S_WAIT: if (cnt == '0) st <= S_EXEC; else cnt <= cnt - 1'b1;
        S_EXEC: if (bad_mv) begin
          err <= 1'b1; f_beot <= 1'b1; ready <= 1'b1; st <= S_IDLE;
        end else begin
          st <= S_IDLE; ready <= 1'b1;
          case (fn_q)
            3'd1: begin
              if (xf_held) begin err <= 1'b1; f_tim <= 1'b1; end else xfer_req <= 1'b1;
              st <= S_WCH; ready <= 1'b0; cnt <= CW'(CHAR_DLY - 1);
            end
            3'd2: if (t_fgap) begin err <= 1'b1; f_eof <= 1'b1; gap_d[unit_q] <= 1'b1; end
                  else begin st <= S_RCH; ready <= 1'b0; cnt <= CW'(CHAR_DLY - 1); end
            3'd3, 3'd5: begin st <= S_SPACE; ready <= 1'b0; end
            3'd4: if (t_rgap) begin err <= 1'b1; f_eof <= 1'b1; gap_d[unit_q] <= 1'b1; end
            3'd6: begin
              f_crc <= 1'b1;
              if (t_fgap) begin err <= 1'b1; f_eof <= 1'b1; gap_d[unit_q] <= 1'b1; end
            end
            3'd7: f_beot <= 1'b1;
            default: ;
          endcase
        end
        S_RCH: if (cnt != '0) cnt <= cnt - 1'b1;
        else if (!t_avail) begin
          rx_byte <= '0; err <= 1'b1; f_crc <= 1'b1; ready <= 1'b1; st <= S_IDLE;
        end else begin
          rx_byte <= t_data;
          if (crc_flag) begin st <= S_CRC; cnt <= CW'(START_DLY - 1); end
          else begin
            if (xf_held) begin err <= 1'b1; f_tim <= 1'b1; end else xfer_req <= 1'b1;
            cnt <= CW'(CHAR_DLY - 1);
          end
        end
        S_WCH: if (cnt != '0) cnt <= cnt - 1'b1;
        else if (crc_flag) begin st <= S_CRC; cnt <= CW'(START_DLY - 1); end
        else begin
          if (xf_held) begin err <= 1'b1; f_tim <= 1'b1; end else xfer_req <= 1'b1;
          cnt <= CW'(CHAR_DLY - 1);
        end
        S_CRC: if (cnt != '0) cnt <= cnt - 1'b1;
        else begin ready <= 1'b1; st <= S_IDLE; end
        S_SPACE: if (sp_gap) begin
          f_eof <= 1'b1; gap_d[unit_q] <= 1'b1; ready <= 1'b1; st <= S_IDLE;
        end else if (sp_end) begin
          err <= 1'b1; ready <= 1'b1; st <= S_IDLE;
          if (mv_rev) f_beot <= 1'b1; else f_crc <= 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R14
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) ready != busy);
  // R2
  step_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) t_step |-> busy);
  // R3
  wlock_stop_chk: assert property (@(posedge clk) disable iff (!rst_n) f_wlk |-> (err && !busy));
  // R9
  tim_err_chk: assert property (@(posedge clk) disable iff (!rst_n) f_tim |-> err);
  // R13
  busy_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
                                (busy && go) |=> (fn_q == $past(fn_q) && unit_q == $past(unit_q)));
endmodule

// File: tb/cassette_seq_tb_top.sv
module cassette_seq_tb_top;
  logic clk = 0, rst_n = 0;
  logic go = 0, crc_flag = 0, ack = 0;
  logic [0:0] go_unit = 0;
  logic [2:0] go_fn = 0;
  logic [7:0] tx_byte = 0;
  logic busy, ready, xfer_req, err, f_crc, f_beot, f_wlk, f_eof, f_tim, t_step;
  logic [7:0] rx_byte, t_wdata, t_data;
  logic [0:0] t_unit;
  logic [2:0] t_op;
  logic t_bot, t_eot, t_wlock, t_fgap, t_rgap, t_avail;

  always #10 clk = ~clk;

  cassette_seq #(.NDRV(2), .START_DLY(10), .CHAR_DLY(5)) dut_i (.*);

  int ln [2][9];
  int nit [2];
  int pit [2], pby [2];
  bit wl [2];
  logic [7:0] wlog [16];
  int nput = 0, ngap = 0, nrew = 0, nclose = 0;
  int errors = 0, checks = 0, cyc = 0;

  function automatic logic [7:0] bdat(int d, int i, int b);
    return 8'(d * 128 + i * 16 + b * 3 + 1);
  endfunction

  always_comb begin
    int u; u = int'(t_unit);
    t_eot   = pit[u] >= nit[u];
    t_bot   = pit[u] == 0 && pby[u] == 0;
    t_fgap  = !t_eot && ln[u][pit[u]] == 0;
    t_rgap  = pit[u] > 0 && pby[u] == 0 && ln[u][pit[u] - 1] == 0;
    t_avail = !t_eot && ln[u][pit[u]] != 0 && pby[u] < ln[u][pit[u]];
    t_data  = bdat(u, pit[u], pby[u]);
    t_wlock = wl[u];
  end

  always @(posedge clk) if (t_step) begin
    int u; u = int'(t_unit);
    case (t_op)
      3'd0: if (pit[u] < nit[u]) begin pit[u] <= pit[u] + 1; pby[u] <= 0; end
      3'd1: if (pby[u] != 0) pby[u] <= 0; else if (pit[u] > 0) pit[u] <= pit[u] - 1;
      3'd2: pby[u] <= pby[u] + 1;
      3'd3: begin wlog[nput % 16] <= t_wdata; nput <= nput + 1; end
      3'd4: ngap <= ngap + 1;
      3'd5: begin pit[u] <= 0; pby[u] <= 0; nrew <= nrew + 1; end
      3'd6: nclose <= nclose + 1;
      default: ;
    endcase
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int fl();
    return int'({err, f_crc, f_beot, f_wlk, f_eof, f_tim});
  endfunction
  localparam int E = 32, C = 16, B = 8, W = 4, F = 2, T = 1;

  task automatic issue(int u, int fn);
    @(negedge clk); go = 1; go_unit = 1'(u); go_fn = 3'(fn);
    @(negedge clk); go = 0;
  endtask

  task automatic wait_done();
    while (!ready) @(negedge clk);
  endtask

  task automatic host_read(int d, int it, int k, bit noack, string req);
    int n = 0;
    forever begin
      @(negedge clk);
      if (ready) break;
      if (xfer_req && !crc_flag && !noack) begin
        chk(req, rx_byte, bdat(d, it, n));
        n++;
        if (n == k) crc_flag = 1;
        else begin ack = 1; @(negedge clk); ack = 0; end
      end
    end
    crc_flag = 0;
  endtask

  task automatic host_write(int k);
    int n = 0;
    forever begin
      @(negedge clk);
      if (ready) break;
      if (xfer_req && !crc_flag) begin
        if (n == k) crc_flag = 1;
        else begin tx_byte = 8'(8'h5A ^ (n * 37)); ack = 1; @(negedge clk); ack = 0; n++; end
      end
    end
    crc_flag = 0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      finish_run();
    end
  end

  initial begin
    int s;
    s = $urandom(17);
    for (int d = 0; d < 2; d++) for (int i = 0; i < 9; i++) ln[d][i] = 0;
    ln[0][0] = 0; ln[0][1] = 3; ln[0][2] = 2; ln[0][3] = 0; ln[0][4] = 4; nit[0] = 5;
    ln[1][0] = 5; ln[1][1] = 3; ln[1][2] = 6; ln[1][3] = 4; nit[1] = 4;
    pit[0] = 0; pby[0] = 0; pit[1] = 0; pby[1] = 0; wl[0] = 0; wl[1] = 0;
    repeat (3) @(negedge clk);
    // R14 reset state
    chk("R14 ready", ready, 1); chk("R14 busy", busy, 0);
    chk("R14 xfer", xfer_req, 0); chk("R14 flags", fl(), 0);
    rst_n = 1;

    // R4 R1 R11: space forward one item from BOT skips leading gap
    issue(0, 6); wait_done();
    chk("R4 pos", pit[0], 2); chk("R11 sfb flags", fl(), C);
    // R6 R7: read with early end-of-record
    issue(0, 2); host_read(0, 2, 1, 0, "R6 byte"); wait_done();
    chk("R7 flags", fl(), 0); chk("R7 pos", pit[0], 3);
    // R8: read starting on gap
    issue(0, 2); host_read(0, 3, 9, 0, "R8 byte"); wait_done();
    chk("R8 gap flags", fl(), E | F); chk("R8 gap pos", pit[0], 4);
    // R5: reverse after gap passes it silently
    issue(0, 4); wait_done();
    chk("R5 rev flags", fl(), 0); chk("R5 rev pos", pit[0], 2);
    // R11: space forward to gap
    issue(0, 5); wait_done();
    chk("R11 sff flags", fl(), F); chk("R11 sff pos", pit[0], 4);
    issue(0, 6); wait_done();
    chk("R11 sfb pos", pit[0], 5);
    // R2: forward at EOT
    issue(0, 6); wait_done();
    chk("R2 eot flags", fl(), E | B); chk("R2 eot pos", pit[0], 5);
    // R11: space reverse to gap
    issue(0, 3); wait_done();
    chk("R11 srf flags", fl(), F); chk("R11 srf pos", pit[0], 3);
    // R5: forward after reverse gap hit
    issue(0, 6); wait_done();
    chk("R5 fwd flags", fl(), C); chk("R5 fwd pos", pit[0], 5);
    // R12: rewind
    issue(0, 7); wait_done();
    chk("R12 rew flags", fl(), B); chk("R12 rew pos", pit[0], 0);
    // R2: reverse at BOT
    issue(0, 4); wait_done();
    chk("R2 bot flags", fl(), E | B); chk("R2 bot pos", pit[0], 0);
    // R8: overrun of a 3-byte record
    issue(0, 2); host_read(0, 1, 3, 0, "R8 byte"); wait_done();
    chk("R8 flags", fl(), E | C); chk("R8 rx", rx_byte, 0); chk("R8 pos", pit[0], 1);
    // R9: host never acknowledges
    issue(0, 7); wait_done();
    issue(0, 2); host_read(0, 1, 99, 1, "R9 byte"); wait_done();
    chk("R9 flags", fl(), E | C | T);
    // R10: write three bytes
    issue(0, 1); host_write(3); wait_done();
    chk("R10 flags", fl(), 0); chk("R10 puts", nput, 3); chk("R10 close", nclose, 1);
    for (int i = 0; i < 3; i++) chk("R10 data", wlog[i], 8'(8'h5A ^ (i * 37)));
    // R12: lay a gap
    issue(0, 0); wait_done();
    chk("R12 gap flags", fl(), 0); chk("R12 gaps", ngap, 1);
    // R3: write-locked drive
    wl[1] = 1;
    issue(1, 1);
    chk("R3 busy", busy, 0); chk("R3 flags", fl(), E | W); chk("R3 ready", ready, 1);
    wl[1] = 0;
    // R13: go while busy is ignored
    pit[0] = 3; s = nrew;
    issue(1, 2);
    repeat (3) @(negedge clk);
    go = 1; go_unit = 0; go_fn = 7; @(negedge clk); go = 0;
    host_read(1, 0, 2, 0, "R13 byte"); wait_done();
    chk("R13 rew", nrew, s); chk("R13 other pos", pit[0], 3);
    chk("R13 flags", fl(), 0); chk("R13 pos", pit[1], 1);
    // R6 R7 R8 random reads on gap-free drive
    for (int r = 0; r < 20; r++) begin
      int it, k, len;
      it = $urandom % 4; k = 1 + $urandom % 7; len = ln[1][it];
      pit[1] = it; pby[1] = 0;
      issue(1, 2); host_read(1, it, k, 0, "R6 rnd byte"); wait_done();
      if (k >= len) begin
        chk("R8 rnd flags", fl(), E | C); chk("R8 rnd pos", pit[1], it);
      end else begin
        chk("R7 rnd flags", fl(), 0); chk("R7 rnd pos", pit[1], it + 1);
      end
    end
    finish_run();
  end
endmodule